// File: doc/BRIEF.md
# Two-Page Buffer DMA Splitter

This block takes one buffer transfer request and turns it into at most two memory burst commands. A buffer may cross one 4 KiB page boundary. The page that holds the tail of the buffer is not assumed to follow the first page. Instead, a separate end pointer names that page.

The first burst starts at the start pointer. It runs to the end of that page, or to the end of the request if the request ends sooner. If bytes remain, a second burst starts at the page-aligned base of the end pointer and carries the rest of the bytes. A local-memory base offset is added to every burst address.

Bursts leave over a valid/ready command port. A one-cycle done pulse marks the end of each request. New requests are held off while a split is in progress.

Top module: `page_split_dma`

## Requirements
- R1: After reset, `cmd_valid_o` and `done_o` are low and `req_ready_o` is high.
- R2: The first burst has address `start + base` and byte count `min(4096 - start[11:0], len)`.
- R3: When the first burst covers the whole request length, no second burst is issued, and `done_o` follows the acceptance of the first burst.
- R4: The second burst has address `(end & ~0xFFF) + base`. It restarts at the end pointer's page base and does not continue from the first burst.
- R5: The byte count of the second burst is the request length minus the byte count of the first burst.
- R6: A request of length zero emits no burst. `done_o` is high in the cycle after that request is accepted.
- R7: Bursts are presented in order, and the second appears only after the first is accepted. While `cmd_valid_o` is high and `cmd_ready_i` is low, the address, count and direction stay unchanged. Every presented burst has a nonzero count.
- R8: `done_o` is high for exactly one cycle, in the cycle after the last burst of a request is accepted.
- R9: `req_ready_o` is low while any burst of a split is pending. Requests offered in that time are ignored and change no burst.
- R10: Start, end, length, direction and base are captured when the request is accepted. Later changes on those inputs have no effect on the bursts. `cmd_dir_o` carries the captured direction on both bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Splitter idle and able to take a request |
| req_start_i | input | ADDR_W | Buffer start pointer |
| req_end_i | input | ADDR_W | Buffer end pointer, naming the second page |
| req_len_i | input | LEN_W | Request length in bytes |
| req_dir_i | input | 1 | Transfer direction |
| base_off_i | input | ADDR_W | Local-memory base offset added to burst addresses |
| cmd_valid_o | output | 1 | Burst command valid |
| cmd_ready_i | input | 1 | Burst command accepted |
| cmd_addr_o | output | ADDR_W | Burst address |
| cmd_len_o | output | LEN_W | Burst byte count |
| cmd_dir_o | output | 1 | Burst direction |
| done_o | output | 1 | One-cycle pulse when the request is finished |

## Verification
The assertions assume that a request never needs more than two pages. That means the length is at most the first-page room plus 4096.

The assertions also assume that the consumer may hold `cmd_ready_i` low for any number of cycles.

The stimulus stays within those limits. It sweeps start offsets at the page edges and the middle. Lengths fall just below, at and just above the first-page room, plus zero and a few fixed sizes. The stall count on the command port varies from zero to two cycles. While a split is pending, the bench offers conflicting requests and changes the request inputs.

// File: rtl/psd_pkg.sv
package psd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_SECOND = 2'd2
  } psd_state_e;
endpackage

// File: rtl/psd_split_calc.sv
module psd_split_calc #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int PAGE_BITS = 12
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] end_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_a_o,
  output logic [LEN_W-1:0]  len_a_o,
  output logic [ADDR_W-1:0] addr_b_o,
  output logic [LEN_W-1:0]  len_b_o,
  output logic              need_b_o
);
  localparam int unsigned PAGE = 1 << PAGE_BITS;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W)'(PAGE - 1));

  logic [LEN_W-1:0] room;

  always_comb begin
    room     = LEN_W'(PAGE) - LEN_W'(start_i[PAGE_BITS-1:0]);
    len_a_o  = (len_i < room) ? len_i : room;
    len_b_o  = len_i - len_a_o;
    need_b_o = (len_b_o != '0);
    addr_a_o = start_i + base_i;
    // second page restarts at the end pointer's page base
    addr_b_o = (end_i & PAGE_MASK) + base_i;
  end
endmodule

// File: rtl/psd_seq.sv
module psd_seq
  import psd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_dir_i,
  input  logic              req_zero_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic              need_b_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic              cmd_dir_o,
  output logic              done_o
);
  psd_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  logic [LEN_W-1:0]  len_a_q, len_b_q;
  logic              need_b_q, dir_q, done_q, done_d;
  logic              take;

  assign req_ready_o = (state_q == ST_IDLE);
  assign take        = req_valid_i & req_ready_o;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          if (req_zero_i) done_d = 1'b1;
          else            state_d = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (cmd_ready_i) begin
          if (need_b_q) state_d = ST_SECOND;
          else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_SECOND: begin
        if (cmd_ready_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      done_q   <= 1'b0;
      addr_a_q <= '0;
      addr_b_q <= '0;
      len_a_q  <= '0;
      len_b_q  <= '0;
      need_b_q <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (take) begin
        addr_a_q <= addr_a_i;
        addr_b_q <= addr_b_i;
        len_a_q  <= len_a_i;
        len_b_q  <= len_b_i;
        need_b_q <= need_b_i;
        dir_q    <= req_dir_i;
      end
    end
  end

  always_comb begin
    cmd_valid_o = (state_q != ST_IDLE);
    cmd_dir_o   = dir_q;
    if (state_q == ST_SECOND) begin
      cmd_addr_o = addr_b_q;
      cmd_len_o  = len_b_q;
    end else begin
      cmd_addr_o = addr_a_q;
      cmd_len_o  = len_a_q;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/page_split_dma.sv
module page_split_dma #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_start_i,
  input  logic [ADDR_W-1:0] req_end_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_dir_i,
  input  logic [ADDR_W-1:0] base_off_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LEN_W-1:0]  cmd_len_o,
  output logic              cmd_dir_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_a, addr_b;
  logic [LEN_W-1:0]  len_a, len_b;
  logic              need_b;

  psd_split_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BITS(PAGE_BITS)
  ) calc_i (
    .start_i (req_start_i),
    .end_i   (req_end_i),
    .len_i   (req_len_i),
    .base_i  (base_off_i),
    .addr_a_o(addr_a),
    .len_a_o (len_a),
    .addr_b_o(addr_b),
    .len_b_o (len_b),
    .need_b_o(need_b)
  );

  psd_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_dir_i  (req_dir_i),
    .req_zero_i (req_len_i == '0),
    .addr_a_i   (addr_a),
    .len_a_i    (len_a),
    .addr_b_i   (addr_b),
    .len_b_i    (len_b),
    .need_b_i   (need_b),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_addr_o (cmd_addr_o),
    .cmd_len_o  (cmd_len_o),
    .cmd_dir_o  (cmd_dir_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/page_split_dma_chk.sv
module page_split_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [LEN_W-1:0]  cmd_len_o,
  input logic              cmd_dir_o,
  input logic              done_o
);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_addr_o)
      && $stable(cmd_len_o) && $stable(cmd_dir_o));

  // R7
  nonzero_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_len_o != '0);

  // R9
  busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !req_ready_o);

  // R8
  done_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_valid_o && cmd_ready_i)
      || $past(req_valid_i && req_ready_o && req_len_i == '0));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o && req_ready_o);
endmodule

bind page_split_dma page_split_dma_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_len_i  (req_len_i),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_addr_o (cmd_addr_o),
  .cmd_len_o  (cmd_len_o),
  .cmd_dir_o  (cmd_dir_o),
  .done_o     (done_o)
);

// File: tb/page_split_dma_tb_top.sv
module page_split_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_start = '0, req_end = '0, base_off = '0;
  logic [13:0] req_len = '0;
  logic        req_dir = 1'b0;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_dir, done;
  logic [31:0] cmd_addr;
  logic [13:0] cmd_len;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  page_split_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_start_i(req_start), .req_end_i(req_end), .req_len_i(req_len),
    .req_dir_i(req_dir), .base_off_i(base_off),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_addr_o(cmd_addr), .cmd_len_o(cmd_len), .cmd_dir_o(cmd_dir),
    .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] e, input int l,
                     input logic d, input logic [31:0] b, input int stall);
    int room, f, r;
    logic [31:0] a1, a2;
    int nb;
    room = 4096 - int'(s[11:0]);
    f    = (l < room) ? l : room;
    r    = l - f;
    a1   = s + b;
    a2   = (e & 32'hFFFF_F000) + b;
    nb   = (l == 0) ? 0 : ((r == 0) ? 1 : 2);

    @(negedge clk);
    check("R9 ready idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_start = s; req_end = e; req_len = 14'(l);
    req_dir = d; base_off = b;
    @(negedge clk);
    req_valid = 1'b0;
    // R10: scramble inputs after capture
    req_start = ~s; req_end = ~e; base_off = b ^ 32'h5A5A_0000;
    req_len = 14'(l + 77); req_dir = ~d;
    if (nb == 0) begin
      check("R6 zero done", {31'd0, done}, 32'd1);
      check("R6 zero no burst", {31'd0, cmd_valid}, 32'd0);
      return;
    end
    for (int k = 0; k < nb; k++) begin
      for (int w = 0; w <= stall; w++) begin
        check(k == 0 ? "R2 valid" : "R7 second valid", {31'd0, cmd_valid}, 32'd1);
        check(k == 0 ? "R2 addr" : "R4 addr", cmd_addr, k == 0 ? a1 : a2);
        check(k == 0 ? "R2 len" : "R5 len", {18'd0, cmd_len}, k == 0 ? 32'(f) : 32'(r));
        check("R10 dir", {31'd0, cmd_dir}, {31'd0, d});
        check("R9 busy", {31'd0, req_ready}, 32'd0);
        check("R8 no early done", {31'd0, done}, 32'd0);
        if (w < stall) begin
          // R9: conflicting request while busy
          req_valid = 1'b1;
          @(negedge clk);
          req_valid = 1'b0;
        end
      end
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
    end
    check(nb == 1 ? "R3 single done" : "R8 done", {31'd0, done}, 32'd1);
    check(nb == 1 ? "R3 no second" : "R8 idle", {31'd0, cmd_valid}, 32'd0);
    @(negedge clk);
    check("R8 pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int offs[6];
    int fixed[7];
    int idx;
    offs  = '{0, 1, 2, 12'h7FF, 12'hFFE, 12'hFFF};
    fixed = '{0, 1, 2, 100, 4095, 4096, 4097};
    #1;
    // R1
    check("R1 valid", {31'd0, cmd_valid}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 ready", {31'd0, req_ready}, 32'd1);
    #11 rst_n = 1'b1;
    idx = 0;
    foreach (offs[oi]) begin
      for (int li = 0; li < 10; li++) begin
        int room, l;
        logic [31:0] s, e, b;
        room = 4096 - offs[oi];
        l = (li < 7) ? fixed[li] : room + (li - 8);
        s = 32'h4000_0000 | (32'(idx) << 12) | 32'(offs[oi]);
        e = 32'h8000_0ABC + (32'(idx) << 13);
        b = 32'h0010_0000 * 32'(oi) + 32'h123;
        run(s, e, l, idx[0], b, idx % 3);
        idx++;
      end
    end
    // back-to-back zero-length requests
    run(32'h0000_0FFF, 32'h0000_1000, 0, 1'b0, 32'h0, 0);
    run(32'h0000_0000, 32'h0000_1000, 0, 1'b1, 32'h0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule